// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes bytes from a single asynchronous serial line and hands each one to the parallel side as an 8-bit word with a one-clock strobe. The line idles high. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Parity, flow control, buffering and transmit logic are not part of it.

A free-running divider makes a sampling tick at sixteen times the bit rate. The divider's terminal count is computed from the clock frequency and bit rate parameters. The line passes through a two-flop synchronizer. A falling edge seen while idle starts a frame. Every bit, including the start and stop bits, is decided by a 2-of-3 majority over samples taken on ticks 7, 8 and 9 of its 16-tick period. A start bit that votes high is treated as noise and the receiver goes back to idle. A stop bit that votes low raises a framing-error strobe, throws the byte away, and makes the receiver wait for the line to go high again before it looks for another start.

Top module: `uart_rx_core`

## Requirements
- R1: A synchronous active-high reset clears the data output to zero, drops both strobes and returns the receiver to idle.
- R2: The sampling tick fires once every CLK_HZ/(16*BAUD) clocks, which is a terminal count of that quotient minus one. A bit period lasts 16 ticks.
- R3: A frame begins only on a high-to-low change of the synchronized line while the receiver is idle. A line held high produces no strobe.
- R4: Each bit value is the majority of three samples on ticks 7, 8 and 9 of its bit period. One disagreeing sample does not change the result. Two disagreeing samples do.
- R5: If the start bit votes high, the receiver returns to idle with no strobe. A correct frame that follows is received normally.
- R6: The eight data bits are taken least significant bit first. rx_data bit i holds the i-th data bit after the start bit.
- R7: When the stop bit votes high, rx_data is loaded with the byte and rx_valid is high for exactly one clock.
- R8: When the stop bit votes low, rx_ferr is high for exactly one clock, rx_valid stays low and rx_data keeps its previous value.
- R9: After a framing error, no new frame starts while the line stays low. A frame is accepted only after the line has been high.
- R10: rx_valid and rx_ferr are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_data | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-clock strobe: rx_data has just been loaded |
| rx_ferr | output | 1 | One-clock strobe: the stop bit was low |

## Verification
The assertions assume that reset is applied at the first clock edge. They also assume that rx_line holds steady for at least three clocks around each sampled tick, so the synchronizer output is well defined. The stimulus drives the line only on falling clock edges and holds each bit for a whole number of 16-tick periods. The only exceptions are deliberate single- or double-sample disturbances aimed at the voting window. The divider is configured so that a tick occurs every clock, and every byte value is sent through a full frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_WAIT  = 3'd4
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int TERM  = 77,
    parameter int DIV_W = 7
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == DIV_W'(TERM));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = line_in;
        s_d.stable = s_q.meta;
        s_d.prev   = s_q.stable;
        line_s     = s_q.stable;
        fall       = s_q.prev & ~s_q.stable;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '1;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
    parameter int SUB_W = 4,
    parameter int V_MID = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SUB_W-1:0] sub,
    input  logic             line_s,
    output logic             bit_val,
    output logic             bit_done
);
    import uart_rx_pkg::*;

    logic [1:0] samp_d, samp_q;

    always_comb begin
        samp_d = samp_q;
        if (tick && sub == SUB_W'(V_MID - 1)) samp_d[0] = line_s;
        if (tick && sub == SUB_W'(V_MID))     samp_d[1] = line_s;
        bit_done = tick && (sub == SUB_W'(V_MID + 1));
        bit_val  = maj3(samp_q[0], samp_q[1], line_s);
    end

    always_ff @(posedge clk) begin
        if (rst) samp_q <= '1;
        else     samp_q <= samp_d;
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int CLK_HZ = 12_000_000,
    parameter int BAUD   = 9600,
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    import uart_rx_pkg::*;

    localparam int TICK_TERM = CLK_HZ / (OVS * BAUD) - 1;
    localparam int DIV_W     = (TICK_TERM > 0) ? $clog2(TICK_TERM + 1) : 1;
    localparam int SUB_W     = $clog2(OVS);
    localparam int BCNT_W    = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e          state;
        logic [SUB_W-1:0]   sub;
        logic [BCNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0]  shreg;
        logic [DATA_W-1:0]  data;
        logic               valid;
        logic               ferr;
    } core_t;

    core_t c_d, c_q;
    logic tick, line_s, fall, bit_val, bit_done;

    uart_rx_tick #(.TERM(TICK_TERM), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    uart_rx_sync u_sync (
        .clk(clk), .rst(rst), .line_in(rx_line), .line_s(line_s), .fall(fall)
    );

    uart_rx_vote #(.SUB_W(SUB_W), .V_MID(OVS / 2)) u_vote (
        .clk(clk), .rst(rst), .tick(tick), .sub(c_q.sub), .line_s(line_s),
        .bit_val(bit_val), .bit_done(bit_done)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.ferr  = 1'b0;
        if (c_q.state != ST_IDLE && c_q.state != ST_WAIT && tick)
            c_d.sub = (c_q.sub == SUB_W'(OVS - 1)) ? '0 : c_q.sub + 1'b1;
        unique case (c_q.state)
            ST_IDLE: begin
                if (fall) begin
                    c_d.state  = ST_START;
                    c_d.sub    = '0;
                    c_d.bitcnt = '0;
                end
            end
            ST_START: begin
                if (bit_done) c_d.state = bit_val ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (bit_done) begin
                    c_d.shreg = {bit_val, c_q.shreg[DATA_W-1:1]};
                    if (c_q.bitcnt == BCNT_W'(DATA_W - 1)) c_d.state = ST_STOP;
                    else c_d.bitcnt = c_q.bitcnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_done) begin
                    if (bit_val) begin
                        c_d.data  = c_q.shreg;
                        c_d.valid = 1'b1;
                        c_d.state = ST_IDLE;
                    end else begin
                        c_d.ferr  = 1'b1;
                        c_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (line_s) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rx_data  = c_q.data;
    assign rx_valid = c_q.valid;
    assign rx_ferr  = c_q.ferr;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
    parameter int TICK_TERM = 77,
    parameter int DATA_W    = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic                   line_s,
    input uart_rx_pkg::rx_state_e state,
    input logic [DATA_W-1:0]      rx_data,
    input logic                   rx_valid,
    input logic                   rx_ferr
);
    import uart_rx_pkg::*;

    int gap_q;
    always_ff @(posedge clk) begin
        if (rst || tick) gap_q <= 0;
        else             gap_q <= gap_q + 1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!rx_valid && !rx_ferr && rx_data == '0 && state == ST_IDLE));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == TICK_TERM));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ferr |=> !rx_ferr);

    // R8
    ferr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ferr) |-> $stable(rx_data));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_ferr));

    // R9
    wait_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !line_s) |=> (state == ST_WAIT));

    // R9
    ferr_to_wait_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ferr |-> (state == ST_WAIT || state == ST_IDLE));
endmodule

bind uart_rx_core uart_rx_chk #(.TICK_TERM(TICK_TERM), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .line_s(line_s), .state(c_q.state),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
    localparam real CLK_PERIOD = 10.0;
    localparam int  CLK_HZ     = 153600;
    localparam int  BAUD       = 9600;
    localparam int  OVS        = 16;
    localparam int  BIT_CLKS   = OVS * (CLK_HZ / (OVS * BAUD));

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, rx_ferr;

    int tests = 0, fails = 0;
    int n_valid = 0, n_ferr = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0, prev_ferr = 1'b0;
    bit done = 1'b0;

    uart_rx_core #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS), .DATA_W(8)) dut (
        .clk(clk), .rst(rst), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin n_valid++; last_byte = rx_data; end
            if (rx_ferr) n_ferr++;
            if (rx_valid && prev_valid) begin
                fails++; $display("FAIL R7 valid width: actual 2+ cycles expected 1");
            end
            if (rx_ferr && prev_ferr) begin
                fails++; $display("FAIL R8 ferr width: actual 2+ cycles expected 1");
            end
            if (rx_valid && rx_ferr) begin
                fails++; $display("FAIL R10 both strobes: actual 1/1 expected exclusive");
            end
        end
        prev_valid = rx_valid;
        prev_ferr  = rx_ferr;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line = 1'b1;
        end
    endtask

    // flips samples on offsets lo..hi of every bit selected by mask (bit 0 = start)
    task automatic send(input logic [7:0] b, input logic stop,
                        input logic [9:0] mask, input int lo, input int hi);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            for (int k = 0; k < BIT_CLKS; k++) begin
                @(negedge clk);
                rx_line = fr[i] ^ (mask[i] && k >= lo && k <= hi);
            end
        end
    endtask

    task automatic frame_ok(input logic [7:0] b, input logic [9:0] mask,
                            input int lo, input int hi, input logic [7:0] exp,
                            input string req);
        int v0, f0;
        v0 = n_valid; f0 = n_ferr;
        send(b, 1'b1, mask, lo, hi);
        idle(BIT_CLKS);
        check(n_valid == v0 + 1 && n_ferr == f0, req, n_valid - v0, 1);
        check(last_byte == exp, req, int'(last_byte), int'(exp));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(rx_data == 8'h00, "R1 data after reset", int'(rx_data), 0);
        check(!rx_valid && !rx_ferr, "R1 strobes after reset", int'({rx_valid, rx_ferr}), 0);
        // R3: idle line gives nothing
        idle(3 * BIT_CLKS);
        check(n_valid == 0 && n_ferr == 0, "R3 idle line", n_valid + n_ferr, 0);

        // R6 R7 R2: every byte value
        for (int v = 0; v < 256; v++)
            frame_ok(8'(v), 10'h000, 0, -1, 8'(v), "R6_R7 byte sweep");

        // R4: one disturbed sample per bit is outvoted
        for (int v = 0; v < 256; v += 37)
            frame_ok(8'(v), 10'h3FF, 9, 9, 8'(v), "R4 single sample outvoted");
        frame_ok(8'hA5, 10'h3FF, 8, 8, 8'hA5, "R4 first sample outvoted");
        frame_ok(8'h5A, 10'h3FF, 10, 10, 8'h5A, "R4 last sample outvoted");
        // R4: two or three disturbed samples flip a data bit (data bit 3 = frame bit 4)
        frame_ok(8'h00, 10'h010, 8, 10, 8'h08, "R4 three samples flip");
        frame_ok(8'hFF, 10'h010, 9, 10, 8'hF7, "R4 two samples flip");

        // R5: start glitch rejected, then a good frame
        begin
            int v0, f0;
            v0 = n_valid; f0 = n_ferr;
            for (int k = 0; k < 6; k++) begin @(negedge clk); rx_line = 1'b0; end
            idle(3 * BIT_CLKS);
            check(n_valid == v0 && n_ferr == f0, "R5 glitch no strobe",
                  n_valid - v0 + n_ferr - f0, 0);
        end
        frame_ok(8'h3C, 10'h000, 0, -1, 8'h3C, "R5 frame after glitch");

        // R8 R9: stop low, line held low, then recovery
        begin
            int v0, f0;
            v0 = n_valid; f0 = n_ferr;
            send(8'hC3, 1'b0, 10'h000, 0, -1);
            for (int k = 0; k < 5 * BIT_CLKS; k++) begin @(negedge clk); rx_line = 1'b0; end
            check(n_ferr == f0 + 1, "R8 ferr strobe", n_ferr - f0, 1);
            check(n_valid == v0, "R8 no valid on bad stop", n_valid - v0, 0);
            check(rx_data == 8'h3C, "R8 data kept", int'(rx_data), 8'h3C);
            idle(2 * BIT_CLKS);
            check(n_valid == v0 && n_ferr == f0 + 1, "R9 no strobe while low",
                  n_valid - v0 + n_ferr - f0, 1);
        end
        frame_ok(8'h81, 10'h000, 0, -1, 8'h81, "R9 frame after recovery");
        // R4: majority on the stop bit itself
        frame_ok(8'h7E, 10'h200, 9, 9, 8'h7E, "R4 stop single sample outvoted");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule